// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block moves data one element at a time on behalf of a set of DMA channels. Every channel's source address, destination address, control word and configuration word sit in a register file outside the block and reach it as flat input vectors. The block scans the channels and picks the lowest-numbered one that may run. It reads one element from memory through a simple request/acknowledge master port and writes it back out. It then reports the channel's new addresses and its control word with a decremented count on a one-cycle update strobe, which the register file applies.

Source and destination element widths are set separately. When they differ, the block reads the larger element in pieces of the source width and writes it in pieces of the destination width. Bytes are taken in ascending address order. A flow field in each channel's configuration ties the transfer to peripheral request lines, where each request is the OR of a single line and a burst line. When a channel's count runs out and its interrupt bit is set, a per-channel terminal-count pulse fires with the update. Reloading a channel from a linked descriptor is the job of a separate loader, which watches the same update strobe.

Top module: `dxe_engine`

## Requirements
- R1: While `engineOn` is low no element is started, so `memReq` stays low. Setting it lets eligible channels run.
- R2: A channel is eligible only while configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0.
- R3: Configuration bits [13:11] are the flow mode. Mode 0 always proceeds, mode 1 needs the destination request, mode 2 needs the source request, and mode 3 needs both. The source peripheral number is configuration bits [5:1], the destination number is bits [10:6], and a request is `reqSingle[n] | reqBurst[n]`.
- R4: Flow modes 4 to 7 make a channel ineligible whatever the request lines hold.
- R5: A channel whose count (control bits [11:0]) is zero is skipped.
- R6: The source width is 1<<ctrl[20:18] bytes and the destination width is 1<<ctrl[23:21] bytes. Codes above the bus width (codes 3 to 7 on a 4-byte bus) count as the bus width. One element holds the larger of the two widths. It is read as consecutive source-width accesses, then written as consecutive destination-width accesses, in ascending byte order. `memSize` carries log2 of the access bytes, and data sits right-aligned and little-endian on the bus.
- R7: Control bit 26 makes the source address advance by the source width after each read. Control bit 27 makes the destination address advance by the destination width after each write. With the bit clear the address stays fixed. The update reports the final addresses.
- R8: After the last write of an element, `updValid` pulses for one cycle with the channel number on `updChan`, the addresses, and the control word with bits [11:0] decreased by one and bits [31:12] unchanged.
- R9: When the new count is zero and control bit 31 is 1, `tcEvent` carries a one-hot bit for that channel in the update cycle. At all other times it is zero.
- R10: Each element goes to the lowest-numbered eligible channel. The scan starts again from channel 0 after every element.
- R11: `memReq` with `memWe`, `memAddr`, `memSize` and `memWdata` holds steady until `memAck`. Each acknowledge completes exactly one access.
- R12: During and after reset, `memReq`, `updValid` and `tcEvent` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| engineOn | input | 1 | Global enable for all transfers |
| chanSrc | input | NUM_CH*ADDR_W | Source address of each channel, channel 0 lowest |
| chanDst | input | NUM_CH*ADDR_W | Destination address of each channel |
| chanCtrl | input | NUM_CH*32 | Control word of each channel |
| chanConf | input | NUM_CH*32 | Configuration word of each channel |
| reqSingle | input | 32 | Single request lines from peripherals |
| reqBurst | input | 32 | Burst request lines from peripherals |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | ADDR_W | Access byte address |
| memSize | output | 3 | log2 of access bytes |
| memWdata | output | 8*BUS_BYTES | Write data, right-aligned |
| memAck | input | 1 | Access done; read data valid |
| memRdata | input | 8*BUS_BYTES | Read data, right-aligned |
| updValid | output | 1 | One-cycle strobe: apply the update to a channel |
| updChan | output | CH_W | Channel being updated |
| updSrc | output | ADDR_W | New source address |
| updDst | output | ADDR_W | New destination address |
| updCtrl | output | 32 | New control word |
| tcEvent | output | NUM_CH | One-hot terminal-count pulse |

## Verification
The hardest case to reach is a mixed-width element whose read pieces land in the middle of the staging buffer while the bus acknowledge arrives after varying delays. Several pieces must collect over many cycles before the first write goes out. The bench cycles its acknowledge delay through 0, 1 and 2 cycles and runs width pairs 1-to-4, 4-to-2 and an out-of-range code against 1-byte writes. Its behavioural model predicts every access and every update from a byte-array memory. Priority is reached by making three channels eligible in one cycle and comparing the order of the update strobes.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  // Bit positions that the register file and the engine both decode
  localparam int WORD_W         = 32;
  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_SRCPER_LSB = 1;
  localparam int CFG_DSTPER_LSB = 6;
  localparam int CFG_FLOW_LSB   = 11;
  localparam int CFG_HALT_BIT   = 18;
  localparam int CTL_CNT_W      = 12;
  localparam int CTL_SW_LSB     = 18;
  localparam int CTL_DW_LSB     = 21;
  localparam int CTL_SINC_BIT   = 26;
  localparam int CTL_DINC_BIT   = 27;
  localparam int CTL_TCIRQ_BIT  = 31;
  localparam int PER_W          = 5;
  localparam int REQ_LINES      = 1 << PER_W;

  typedef enum logic [2:0] {
    ST_SCAN   = 3'd0,
    ST_READ   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_UPDATE = 3'd3,
    ST_SETTLE = 3'd4
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rdStep;
    logic wrStep;
    logic wrPhase;
  } dpStrobe_t;

  function automatic logic [2:0] clampLog(input logic [2:0] code, input logic [2:0] maxLog);
    return (code > maxLog) ? maxLog : code;
  endfunction
endpackage

// File: rtl/dxe_eligible.sv
module dxe_eligible
  import dxe_pkg::*;
(
  input  logic                 engineOn,
  input  logic [WORD_W-1:0]    conf,
  input  logic [WORD_W-1:0]    ctrl,
  input  logic [REQ_LINES-1:0] reqAny,
  output logic                 eligible
);
  logic [PER_W-1:0] srcPer;
  logic [PER_W-1:0] dstPer;
  logic [2:0]       flowMode;
  logic             flowOk;
  logic             runnable;

  always_comb begin
    srcPer   = conf[CFG_SRCPER_LSB +: PER_W];
    dstPer   = conf[CFG_DSTPER_LSB +: PER_W];
    flowMode = conf[CFG_FLOW_LSB +: 3];
    case (flowMode)
      3'd0:    flowOk = 1'b1;
      3'd1:    flowOk = reqAny[dstPer];
      3'd2:    flowOk = reqAny[srcPer];
      3'd3:    flowOk = reqAny[srcPer] & reqAny[dstPer];
      default: flowOk = 1'b0;   // modes 4..7 never run
    endcase
    runnable = conf[CFG_EN_BIT] & ~conf[CFG_HALT_BIT] & (ctrl[CTL_CNT_W-1:0] != '0);
    eligible = engineOn & runnable & flowOk;
  end
endmodule

// File: rtl/dxe_ctrl.sv
module dxe_ctrl
  import dxe_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     engineOn,
  input  logic [NUM_CH*WORD_W-1:0] chanConf,
  input  logic [NUM_CH*WORD_W-1:0] chanCtrl,
  input  logic [REQ_LINES-1:0]     reqAny,
  input  logic                     memAck,
  input  logic                     rdLast,
  input  logic                     wrLast,
  input  logic                     tcHit,
  output logic                     memReq,
  output logic                     memWe,
  output dpStrobe_t                strobe,
  output logic [CH_W-1:0]          pickChan,
  output logic                     updValid,
  output logic [CH_W-1:0]          updChan,
  output logic [NUM_CH-1:0]        tcEvent
);
  engState_t         state;
  logic [CH_W-1:0]   selChan;
  logic [NUM_CH-1:0] eligVec;
  logic              anyElig;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    dxe_eligible u_elig (
      .engineOn (engineOn),
      .conf     (chanConf[c*WORD_W +: WORD_W]),
      .ctrl     (chanCtrl[c*WORD_W +: WORD_W]),
      .reqAny   (reqAny),
      .eligible (eligVec[c])
    );
  end

  // Lowest channel number wins
  always_comb begin
    pickChan = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligVec[c]) pickChan = CH_W'(c);
    end
    anyElig = |eligVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SCAN;
      selChan <= '0;
    end else begin
      case (state)
        ST_SCAN: if (anyElig) begin
          state   <= ST_READ;
          selChan <= pickChan;
        end
        ST_READ:   if (memAck && rdLast) state <= ST_WRITE;
        ST_WRITE:  if (memAck && wrLast) state <= ST_UPDATE;
        ST_UPDATE: state <= ST_SETTLE;   // register file applies update here
        default:   state <= ST_SCAN;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_SCAN) && anyElig;
    strobe.rdStep  = (state == ST_READ) && memAck;
    strobe.wrStep  = (state == ST_WRITE) && memAck;
    strobe.wrPhase = (state == ST_WRITE);
    memReq         = (state == ST_READ) || (state == ST_WRITE);
    memWe          = (state == ST_WRITE);
    updValid       = (state == ST_UPDATE);
    updChan        = selChan;
    tcEvent        = '0;
    if (updValid && tcHit) tcEvent[selChan] = 1'b1;
  end

  assert_off_no_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && !engineOn) |=> !memReq);
  assert_tc_with_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tcEvent) && (!(|tcEvent) || updValid));
  assert_pick_eligible_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> eligVec[pickChan]);
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));
  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rstN |=> (!memReq && !updValid));
endmodule

// File: rtl/dxe_datapath.sv
module dxe_datapath
  import dxe_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DATA_W   = 8 * BUS_BYTES,
  localparam int MAX_LOG  = $clog2(BUS_BYTES),
  localparam int IDX_W    = MAX_LOG + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [CH_W-1:0]          pickChan,
  input  logic [NUM_CH*ADDR_W-1:0] chanSrc,
  input  logic [NUM_CH*ADDR_W-1:0] chanDst,
  input  logic [NUM_CH*WORD_W-1:0] chanCtrl,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [2:0]               memSize,
  output logic [DATA_W-1:0]        memWdata,
  output logic                     rdLast,
  output logic                     wrLast,
  output logic                     tcHit,
  output logic [ADDR_W-1:0]        updSrc,
  output logic [ADDR_W-1:0]        updDst,
  output logic [WORD_W-1:0]        updCtrl
);
  logic [ADDR_W-1:0]    srcAddr;
  logic [ADDR_W-1:0]    dstAddr;
  logic [WORD_W-1:0]    ctrlReg;
  logic [DATA_W-1:0]    dataBuf;
  logic [DATA_W-1:0]    nextBuf;
  logic [DATA_W-1:0]    rdShift;
  logic [DATA_W-1:0]    wrShift;
  logic [IDX_W-1:0]     rdIdx;
  logic [IDX_W-1:0]     wrIdx;
  logic [2:0]           swLog;
  logic [2:0]           dwLog;
  logic [2:0]           maxLog;
  logic [IDX_W-1:0]     rdLastIdx;
  logic [IDX_W-1:0]     wrLastIdx;
  logic [CTL_CNT_W-1:0] count;
  int                   rdOff;
  int                   wrOff;
  int                   swBytes;
  int                   dwBytes;

  always_comb begin
    swLog     = clampLog(ctrlReg[CTL_SW_LSB +: 3], 3'(MAX_LOG));
    dwLog     = clampLog(ctrlReg[CTL_DW_LSB +: 3], 3'(MAX_LOG));
    maxLog    = (swLog > dwLog) ? swLog : dwLog;
    rdLastIdx = IDX_W'((1 << (maxLog - swLog)) - 1);
    wrLastIdx = IDX_W'((1 << (maxLog - dwLog)) - 1);
    rdLast    = (rdIdx == rdLastIdx);
    wrLast    = (wrIdx == wrLastIdx);
    swBytes   = 1 << swLog;
    dwBytes   = 1 << dwLog;
    count     = ctrlReg[CTL_CNT_W-1:0];
  end

  // Place the arriving read piece at its byte offset in the staging buffer
  always_comb begin
    rdOff   = int'(rdIdx) << swLog;
    rdShift = memRdata << (8 * rdOff);
    nextBuf = dataBuf;
    for (int b = 0; b < BUS_BYTES; b++) begin
      if (b >= rdOff && b < rdOff + swBytes) nextBuf[8*b +: 8] = rdShift[8*b +: 8];
    end
  end

  // Present the current write piece right-aligned
  always_comb begin
    wrOff   = int'(wrIdx) << dwLog;
    wrShift = dataBuf >> (8 * wrOff);
    for (int b = 0; b < BUS_BYTES; b++) begin
      memWdata[8*b +: 8] = (b < dwBytes) ? wrShift[8*b +: 8] : 8'h00;
    end
    memAddr = strobe.wrPhase ? dstAddr : srcAddr;
    memSize = strobe.wrPhase ? dwLog : swLog;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      ctrlReg <= '0;
      dataBuf <= '0;
      rdIdx   <= '0;
      wrIdx   <= '0;
    end else if (strobe.load) begin
      srcAddr <= chanSrc[pickChan*ADDR_W +: ADDR_W];
      dstAddr <= chanDst[pickChan*ADDR_W +: ADDR_W];
      ctrlReg <= chanCtrl[pickChan*WORD_W +: WORD_W];
      dataBuf <= '0;
      rdIdx   <= '0;
      wrIdx   <= '0;
    end else begin
      if (strobe.rdStep) begin
        dataBuf <= nextBuf;
        rdIdx   <= rdIdx + 1'b1;
        if (ctrlReg[CTL_SINC_BIT]) srcAddr <= srcAddr + (ADDR_W'(1) << swLog);
      end
      if (strobe.wrStep) begin
        wrIdx <= wrIdx + 1'b1;
        if (ctrlReg[CTL_DINC_BIT]) dstAddr <= dstAddr + (ADDR_W'(1) << dwLog);
      end
    end
  end

  always_comb begin
    updSrc  = srcAddr;
    updDst  = dstAddr;
    updCtrl = {ctrlReg[WORD_W-1:CTL_CNT_W], count - 1'b1};
    tcHit   = ctrlReg[CTL_TCIRQ_BIT] && (count == CTL_CNT_W'(1));
  end

  assert_live_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (ctrlReg[CTL_CNT_W-1:0] != '0));
  assert_src_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStep && !ctrlReg[CTL_SINC_BIT]) |=> $stable(srcAddr));
  assert_dst_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStep && !ctrlReg[CTL_DINC_BIT]) |=> $stable(dstAddr));
endmodule

// File: rtl/dxe_engine.sv
module dxe_engine
  import dxe_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DATA_W   = 8 * BUS_BYTES
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     engineOn,
  input  logic [NUM_CH*ADDR_W-1:0] chanSrc,
  input  logic [NUM_CH*ADDR_W-1:0] chanDst,
  input  logic [NUM_CH*32-1:0]     chanCtrl,
  input  logic [NUM_CH*32-1:0]     chanConf,
  input  logic [31:0]              reqSingle,
  input  logic [31:0]              reqBurst,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [2:0]               memSize,
  output logic [DATA_W-1:0]        memWdata,
  input  logic                     memAck,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     updValid,
  output logic [CH_W-1:0]          updChan,
  output logic [ADDR_W-1:0]        updSrc,
  output logic [ADDR_W-1:0]        updDst,
  output logic [31:0]              updCtrl,
  output logic [NUM_CH-1:0]        tcEvent
);
  dpStrobe_t       strobe;
  logic [CH_W-1:0] pickChan;
  logic            rdLast;
  logic            wrLast;
  logic            tcHit;
  logic [31:0]     reqAny;

  assign reqAny = reqSingle | reqBurst;

  dxe_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .engineOn (engineOn),
    .chanConf (chanConf),
    .chanCtrl (chanCtrl),
    .reqAny   (reqAny),
    .memAck   (memAck),
    .rdLast   (rdLast),
    .wrLast   (wrLast),
    .tcHit    (tcHit),
    .memReq   (memReq),
    .memWe    (memWe),
    .strobe   (strobe),
    .pickChan (pickChan),
    .updValid (updValid),
    .updChan  (updChan),
    .tcEvent  (tcEvent)
  );

  dxe_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pickChan (pickChan),
    .chanSrc  (chanSrc),
    .chanDst  (chanDst),
    .chanCtrl (chanCtrl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memWdata (memWdata),
    .rdLast   (rdLast),
    .wrLast   (wrLast),
    .tcHit    (tcHit),
    .updSrc   (updSrc),
    .updDst   (updDst),
    .updCtrl  (updCtrl)
  );

  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memSize) && $stable(memWdata)));
endmodule

// File: tb/dxe_engine_bench.sv
module dxe_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
  } acc_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic engineOn = 1'b0;
  logic [NCH*32-1:0] chanSrc, chanDst, chanCtrl, chanConf;
  logic [31:0] reqSingle = '0;
  logic [31:0] reqBurst = '0;
  logic memReq, memWe;
  logic [31:0] memAddr;
  logic [2:0]  memSize;
  logic [31:0] memWdata;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic updValid;
  logic [1:0]  updChan;
  logic [31:0] updSrc, updDst, updCtrl;
  logic [NCH-1:0] tcEvent;

  logic [31:0] bSrc [NCH];
  logic [31:0] bDst [NCH];
  logic [31:0] bCtrl[NCH];
  logic [31:0] bConf[NCH];
  logic [7:0]  mem  [256];

  int checks = 0;
  int errors = 0;
  acc_t expQ[$];
  int updLog[$];
  bit modelBusy = 0;
  int expCh;
  logic [31:0] expSrc, expDst, expCtrl;
  logic [NCH-1:0] expTc;
  int waitCnt = 0, ackDelay = 0;
  bit holdValid = 0;
  logic [31:0] hAddr, hData;
  logic hWe;
  logic [2:0] hSize;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chanSrc[c*32 +: 32]  = bSrc[c];
      chanDst[c*32 +: 32]  = bDst[c];
      chanCtrl[c*32 +: 32] = bCtrl[c];
      chanConf[c*32 +: 32] = bConf[c];
    end
  end

  dxe_engine #(.NUM_CH(NCH), .ADDR_W(32), .BUS_BYTES(4)) u_dxe_engine (
    .clk(clk), .rstN(rstN), .engineOn(engineOn),
    .chanSrc(chanSrc), .chanDst(chanDst), .chanCtrl(chanCtrl), .chanConf(chanConf),
    .reqSingle(reqSingle), .reqBurst(reqBurst),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .updValid(updValid), .updChan(updChan), .updSrc(updSrc), .updDst(updDst),
    .updCtrl(updCtrl), .tcEvent(tcEvent)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(int cnt, int sw, int dw, bit si, bit di, bit irq);
    logic [31:0] v = '0;
    v[11:0] = 12'(cnt); v[20:18] = 3'(sw); v[23:21] = 3'(dw);
    v[26] = si; v[27] = di; v[31] = irq; v[15:12] = 4'h5; // upper junk kept
    return v;
  endfunction

  function automatic logic [31:0] mkConf(bit en, bit halt, int flow, int sp, int dp);
    logic [31:0] v = '0;
    v[0] = en; v[18] = halt; v[13:11] = 3'(flow); v[5:1] = 5'(sp); v[10:6] = 5'(dp);
    return v;
  endfunction

  function automatic bit modelElig(int c);
    logic [31:0] cf = bConf[c];
    logic [31:0] rq = reqSingle | reqBurst;
    bit fok;
    case (cf[13:11])
      3'd0: fok = 1;
      3'd1: fok = rq[cf[10:6]];
      3'd2: fok = rq[cf[5:1]];
      3'd3: fok = rq[cf[5:1]] && rq[cf[10:6]];
      default: fok = 0;
    endcase
    return engineOn && cf[0] && !cf[18] && (bCtrl[c][11:0] != 0) && fok;
  endfunction

  task automatic predict();
    int pick = -1;
    int sl, dl, sw, dw, tot;
    logic [7:0] bytes [4];
    logic [31:0] s, d, data;
    acc_t e;
    if (modelBusy) return;
    for (int c = NCH - 1; c >= 0; c--) if (modelElig(c)) pick = c;
    if (pick < 0) return;
    sl = (bCtrl[pick][20:18] > 2) ? 2 : int'(bCtrl[pick][20:18]);
    dl = (bCtrl[pick][23:21] > 2) ? 2 : int'(bCtrl[pick][23:21]);
    sw = 1 << sl; dw = 1 << dl; tot = (sw > dw) ? sw : dw;
    s = bSrc[pick]; d = bDst[pick];
    for (int k = 0; k < tot / sw; k++) begin
      for (int b = 0; b < sw; b++) bytes[k*sw + b] = mem[(s + b) & 255];
      e = '{we: 1'b0, addr: s, size: 3'(sl), data: 32'h0};
      expQ.push_back(e);
      if (bCtrl[pick][26]) s = s + sw;
    end
    for (int j = 0; j < tot / dw; j++) begin
      data = '0;
      for (int b = 0; b < dw; b++) data[8*b +: 8] = bytes[j*dw + b];
      e = '{we: 1'b1, addr: d, size: 3'(dl), data: data};
      expQ.push_back(e);
      if (bCtrl[pick][27]) d = d + dw;
    end
    expCh = pick; expSrc = s; expDst = d;
    expCtrl = {bCtrl[pick][31:12], bCtrl[pick][11:0] - 12'd1};
    expTc = '0;
    if (expCtrl[11:0] == 0 && bCtrl[pick][31]) expTc[pick] = 1'b1;
    modelBusy = 1;
  endtask

  task automatic service();
    acc_t e;
    if (expQ.size() == 0) begin
      check(0, "R10", "access with no eligible channel", memAddr, 0);
    end else begin
      e = expQ.pop_front();
      check(memWe == e.we && memSize == e.size && memAddr == e.addr, "R6,R7",
            "access we/size/addr", {memWe, memSize, memAddr}, {e.we, e.size, e.addr});
      if (e.we) check(memWdata == e.data, "R6", "write data", memWdata, e.data);
    end
    if (memWe) begin
      for (int b = 0; b < (1 << memSize); b++) mem[(memAddr + b) & 255] = memWdata[8*b +: 8];
      memRdata = '0;
    end else begin
      memRdata = '0;
      for (int b = 0; b < (1 << memSize); b++) memRdata[8*b +: 8] = mem[(memAddr + b) & 255];
    end
    memAck = 1; waitCnt = 0; holdValid = 0;
    ackDelay = (ackDelay + 1) % 3;
  endtask

  task automatic handleUpd();
    if (!modelBusy || expQ.size() != 0) begin
      check(0, "R8", "update before its accesses", updChan, expCh);
      return;
    end
    check(updChan == 2'(expCh), "R10", "updated channel", updChan, expCh);
    check(updSrc == expSrc, "R7", "final source address", updSrc, expSrc);
    check(updDst == expDst, "R7", "final destination address", updDst, expDst);
    check(updCtrl == expCtrl, "R8", "control writeback", updCtrl, expCtrl);
    check(tcEvent == expTc, "R9", "terminal count pulse", tcEvent, expTc);
    bSrc[expCh] = expSrc; bDst[expCh] = expDst; bCtrl[expCh] = expCtrl;
    updLog.push_back(expCh);
    modelBusy = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    predict();
    if (memAck) begin
      memAck = 0; memRdata = '0; holdValid = 0; waitCnt = 0;
    end else if (memReq) begin
      if (holdValid)
        check(memAddr == hAddr && memWe == hWe && memSize == hSize && memWdata == hData,
              "R11", "request held until ack", memAddr, hAddr);
      if (waitCnt >= ackDelay) service();
      else begin
        waitCnt++; holdValid = 1;
        hAddr = memAddr; hWe = memWe; hSize = memSize; hData = memWdata;
      end
    end
    if (updValid) handleUpd();
    else if (|tcEvent) check(0, "R9", "tc pulse without update", tcEvent, 0);
    predict();
  endtask

  task automatic runIdle(input string tag);
    int quiet = 0;
    int n = 0;
    while (quiet < 10 && n < 3000) begin
      tick(); n++;
      if (!modelBusy && !memReq && !updValid) quiet++; else quiet = 0;
    end
    check(quiet >= 10, tag, "engine drained", n, 0);
  endtask

  task automatic expectQuiet(input string tag, input string what, input int cycles);
    int busy = 0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (memReq || updValid || modelBusy) busy++;
    end
    check(busy == 0, tag, what, busy, 0);
  endtask

  task automatic checkLog(input string tag, input string what, input int want[$]);
    bit same = (updLog.size() == want.size());
    if (same) for (int i = 0; i < want.size(); i++) if (updLog[i] != want[i]) same = 0;
    check(same, tag, what, updLog.size(), want.size());
    updLog.delete();
  endtask

  task automatic setChan(int c, logic [31:0] s, logic [31:0] d, logic [31:0] ct, logic [31:0] cf);
    bSrc[c] = s; bDst[c] = d; bCtrl[c] = ct; bConf[c] = cf;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    for (int c = 0; c < NCH; c++) setChan(c, 0, 0, 0, 0);
    // R12: reset state
    repeat (3) @(negedge clk);
    check(!memReq && !updValid && tcEvent == 0, "R12", "outputs in reset",
          {memReq, updValid, tcEvent}, 0);
    rstN = 1;
    @(negedge clk);
    check(!memReq && !updValid && tcEvent == 0, "R12", "outputs after reset",
          {memReq, updValid, tcEvent}, 0);

    // R1: global enable gates everything
    setChan(0, 32'h10, 32'h80, mkCtrl(2, 2, 2, 1, 1, 1), mkConf(1, 0, 0, 0, 0));
    expectQuiet("R1", "no traffic while engine off", 30);
    engineOn = 1;
    runIdle("R1");
    checkLog("R1", "two elements after enable", '{0, 0});

    // R6: width mixes, R7 address stepping
    setChan(1, 32'h20, 32'h90, mkCtrl(2, 0, 2, 1, 1, 0), mkConf(1, 0, 0, 0, 0));
    runIdle("R6");
    checkLog("R6", "byte-to-word elements", '{1, 1});
    setChan(1, 32'h40, 32'hA0, mkCtrl(1, 2, 1, 1, 1, 1), mkConf(1, 0, 0, 0, 0));
    runIdle("R6");
    checkLog("R6", "word-to-halfword element", '{1});
    setChan(3, 32'h51, 32'hC3, mkCtrl(2, 7, 0, 0, 0, 1), mkConf(1, 0, 0, 0, 0));
    runIdle("R7");
    checkLog("R7", "clamped width, fixed addresses", '{3, 3});

    // R2: halt and channel enable
    setChan(2, 32'h60, 32'hB0, mkCtrl(3, 1, 1, 1, 1, 1), mkConf(1, 1, 0, 0, 0));
    expectQuiet("R2", "halted channel idle", 25);
    bConf[2] = mkConf(0, 0, 0, 0, 0);
    expectQuiet("R2", "disabled channel idle", 25);
    bConf[2] = mkConf(1, 0, 0, 0, 0);
    runIdle("R2");
    checkLog("R2", "released channel runs", '{2, 2, 2});

    // R3: flow modes with request lines
    setChan(0, 32'h70, 32'hD0, mkCtrl(1, 2, 2, 1, 1, 1), mkConf(1, 0, 1, 0, 9));
    expectQuiet("R3", "mode 1 waits for destination request", 20);
    reqBurst[9] = 1'b1;
    runIdle("R3");
    checkLog("R3", "mode 1 runs on burst line", '{0});
    reqBurst = '0;
    setChan(0, 32'h74, 32'hD4, mkCtrl(1, 2, 2, 1, 1, 0), mkConf(1, 0, 2, 4, 9));
    reqSingle[9] = 1'b1;
    expectQuiet("R3", "mode 2 ignores destination request", 20);
    reqSingle[4] = 1'b1;
    runIdle("R3");
    checkLog("R3", "mode 2 runs on source request", '{0});
    reqSingle = '0;
    setChan(0, 32'h78, 32'hD8, mkCtrl(1, 2, 2, 1, 1, 0), mkConf(1, 0, 3, 3, 20));
    reqSingle[3] = 1'b1;
    expectQuiet("R3", "mode 3 needs both requests", 20);
    reqBurst[20] = 1'b1;
    runIdle("R3");
    checkLog("R3", "mode 3 runs with both", '{0});

    // R4: reserved flow modes
    reqSingle = '1; reqBurst = '1;
    setChan(0, 32'h7C, 32'hDC, mkCtrl(2, 2, 2, 1, 1, 0), mkConf(1, 0, 5, 3, 20));
    expectQuiet("R4", "flow mode 5 never runs", 20);
    bConf[0] = mkConf(1, 0, 7, 3, 20);
    expectQuiet("R4", "flow mode 7 never runs", 20);
    bConf[0] = '0;
    reqSingle = '0; reqBurst = '0;

    // R5: zero count skipped
    setChan(1, 32'h30, 32'hE0, mkCtrl(0, 2, 2, 1, 1, 1), mkConf(1, 0, 0, 0, 0));
    expectQuiet("R5", "zero count skipped", 25);

    // R10: priority and rescan from channel 0
    setChan(3, 32'h00, 32'hF0, mkCtrl(2, 2, 2, 1, 1, 1), mkConf(1, 0, 0, 0, 0));
    setChan(2, 32'h08, 32'hE8, mkCtrl(1, 1, 0, 1, 1, 1), mkConf(1, 0, 0, 0, 0));
    setChan(1, 32'h18, 32'hC8, mkCtrl(2, 0, 0, 1, 0, 1), mkConf(1, 0, 0, 0, 0));
    runIdle("R10");
    checkLog("R10", "lowest channel first", '{1, 1, 2, 3, 3});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule